// File: doc/BRIEF.md
# Prioritised External Interrupt Router

This block takes NSRC level-sensitive interrupt inputs from devices and routes them to NCTX hart contexts. A context is one privilege mode of one hardware thread. Each source has a small priority value. Each context has its own enable mask over the sources and its own priority threshold. A source that is pending, enabled for a context and ranked above that context's threshold raises the context's interrupt line.

Software serves an interrupt in two bus operations on the context's claim/complete word. A read returns the best candidate source ID and takes ownership of that source, so no context sees it until the handler ends. A write of the same ID back releases the source. If the device still holds its line high, the source becomes pending again.

Registers sit on a simple bus with one word per request. Addresses are byte addresses and must be word aligned. Source IDs run from 1 to NSRC, and ID 0 means "no source".

Top module: `prio_irq_hub`

## Requirements
- R1: After reset every priority, enable bit and threshold is 0, no source is pending or claimed, every `ctx_irq` bit is low and reads of any register return 0.
- R2: The priority of source k is a 3-bit value at byte address 4·k, and writes keep only the low 3 bits. Addresses for ID 0 and for IDs above NSRC read 0 and ignore writes.
- R3: The enable word w of context c is at 0x2000 + 0x80·c + 4·w. Bit (k mod 32) of word (k div 32) enables source k, and bit 0 of word 0 always reads 0.
- R4: The threshold of context c is a 3-bit value at 0x200000 + 0x1000·c.
- R5: `ctx_irq[c]` is high exactly when some source is pending, enabled for c and has a priority strictly greater than the threshold of c. The line follows register changes in the cycle after the write.
- R6: A read of the claim/complete word at 0x200000 + 0x1000·c + 4 returns the eligible source with the highest priority. Ties go to the lower ID, and the read returns 0 when no source qualifies.
- R7: A claim clears the source's pending state and masks it for every context until completion, even while its input stays high.
- R8: A write of a claimed ID to any claim/complete word releases the source. If the input is still high, the source is pending again from the next cycle. If the input is low, the source stays quiet.
- R9: A completion write whose ID is not currently claimed changes nothing.
- R10: Read data appears on `bus_rdata` in the cycle after the request and is 0 in cycles without a read.
- R11: A high input sets the source's pending state. That state holds after the input falls, until a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level interrupt inputs; bit k is source k |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| ctx_irq | output | NCTX | Interrupt line per context |

## Verification
The bench sweeps every pair of priority and threshold on both contexts. A comparison written as greater-or-equal would raise the line where the threshold equals the priority. It claims sources in patterns with deliberate priority ties, and an arbiter that favours the last match would return the higher ID first. It also holds a claimed source's input high across a completion with the wrong ID. A gateway that re-arms too early, or a completion that ignores ownership, would hand the source out twice. It also pulses an input for a single cycle, which a design without pending storage would lose.

// File: rtl/prio_irq_hub.sv
`timescale 1ns/1ps
module prio_irq_hub #(
  parameter int NSRC   = 6,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   ctx_irq
);
  localparam int IDW = 10;
  localparam logic [31:0] EN_BASE  = 32'h0000_2000;
  localparam logic [31:0] CTL_BASE = 32'h0020_0000;
  localparam logic [31:0] EN_END   = EN_BASE + 32'h80 * NCTX;
  localparam logic [31:0] CTL_END  = CTL_BASE + 32'h1000 * NCTX;

  logic [PRIO_W-1:0] prio   [1:NSRC];
  logic [NSRC:1]     en     [NCTX];
  logic [PRIO_W-1:0] thresh [NCTX];
  logic [NSRC:1]     pend, claimed, pend_n, claimed_n;
  logic [IDW-1:0]    best   [NCTX];

  logic [31:0] a32, rd_val;
  logic        is_prio, is_en, is_ctl;
  int          p_id, en_ctx, en_word, ctl_ctx;
  logic [11:0] ctl_off;
  logic        claim_go, cmpl_go, cmpl_ok;
  logic [IDW-1:0] claim_id, cmpl_id;

  assign a32     = 32'(bus_addr);
  assign is_prio = a32 < 32'h1000;
  assign is_en   = a32 >= EN_BASE && a32 < EN_END;
  assign is_ctl  = a32 >= CTL_BASE && a32 < CTL_END;
  assign p_id    = int'(a32[11:2]);
  assign en_ctx  = int'((a32 - EN_BASE) >> 7);
  assign en_word = int'(a32[6:2]);
  assign ctl_ctx = int'((a32 - CTL_BASE) >> 12);
  assign ctl_off = a32[11:0];
  assign cmpl_id = bus_wdata[IDW-1:0];

  always_comb begin
    logic [PRIO_W-1:0] bp;
    for (int c = 0; c < NCTX; c++) begin
      best[c] = '0;
      bp = thresh[c];
      for (int k = 1; k <= NSRC; k++)
        if (pend[k] && en[c][k] && prio[k] > bp) begin
          bp = prio[k];
          best[c] = IDW'(k);
        end
      ctx_irq[c] = best[c] != '0;
    end
  end

  always_comb begin
    claim_go = bus_req && !bus_we && is_ctl && ctl_off == 12'h004;
    cmpl_go  = bus_req && bus_we && is_ctl && ctl_off == 12'h004;
    claim_id = '0;
    for (int c = 0; c < NCTX; c++)
      if (c == ctl_ctx) claim_id = best[c];
    cmpl_ok = 1'b0;
    for (int k = 1; k <= NSRC; k++)
      if (cmpl_go && cmpl_id == IDW'(k) && claimed[k]) cmpl_ok = 1'b1;
  end

  always_comb begin
    pend_n    = pend;
    claimed_n = claimed;
    for (int k = 1; k <= NSRC; k++) begin
      if (claim_go && claim_id == IDW'(k)) begin
        pend_n[k]    = 1'b0;
        claimed_n[k] = 1'b1;
      end
      if (cmpl_ok && cmpl_id == IDW'(k)) claimed_n[k] = 1'b0;
    end
    pend_n = pend_n | (src_i & ~claimed_n);
  end

  always_comb begin
    rd_val = '0;
    if (is_prio) begin
      for (int k = 1; k <= NSRC; k++)
        if (p_id == k) rd_val = 32'(prio[k]);
    end else if (is_en) begin
      for (int c = 0; c < NCTX; c++)
        for (int k = 1; k <= NSRC; k++)
          if (c == en_ctx && k / 32 == en_word) rd_val[k % 32] = en[c][k];
    end else if (is_ctl) begin
      for (int c = 0; c < NCTX; c++)
        if (c == ctl_ctx) begin
          if (ctl_off == 12'h000) rd_val = 32'(thresh[c]);
          else if (ctl_off == 12'h004) rd_val = 32'(best[c]);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      pend      <= '0;
      claimed   <= '0;
      for (int k = 1; k <= NSRC; k++) prio[k] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]     <= '0;
        thresh[c] <= '0;
      end
    end else begin
      bus_rdata <= (bus_req && !bus_we) ? rd_val : 32'h0;
      pend      <= pend_n;
      claimed   <= claimed_n;
      if (bus_req && bus_we) begin
        if (is_prio)
          for (int k = 1; k <= NSRC; k++)
            if (p_id == k) prio[k] <= bus_wdata[PRIO_W-1:0];
        if (is_en)
          for (int c = 0; c < NCTX; c++)
            for (int k = 1; k <= NSRC; k++)
              if (c == en_ctx && k / 32 == en_word) en[c][k] <= bus_wdata[k % 32];
        if (is_ctl && ctl_off == 12'h000)
          for (int c = 0; c < NCTX; c++)
            if (c == ctl_ctx) thresh[c] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  a_r7_pend_vs_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & claimed)));

  a_r7_claim_takes_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_go && claim_id != '0) |=> claimed[$past(claim_id)]);

  a_r9_stray_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_go && !cmpl_ok) |=> $stable(claimed));

  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_req && !bus_we) |-> bus_rdata == 32'h0);

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx_chk
    a_r5_top_threshold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh[g] == {PRIO_W{1'b1}}) |-> !ctx_irq[g]);
    a_r5_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] == '0) |-> !ctx_irq[g]);
  end
endmodule

// File: tb/tb_prio_irq_hub.sv
`timescale 1ns/1ps
module tb_prio_irq_hub;
  localparam int NSRC = 6;
  localparam int NCTX = 2;

  logic clk = 0, rst_n = 0;
  logic [NSRC:1] src_i = '0;
  logic bus_req = 0, bus_we = 0;
  logic [25:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCTX-1:0] ctx_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  prio_irq_hub #(.NSRC(NSRC), .NCTX(NCTX)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [25:0] a_prio(int k); return 26'(4 * k); endfunction
  function automatic logic [25:0] a_en(int c);   return 26'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [25:0] a_thr(int c);  return 26'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [25:0] a_clm(int c);  return 26'(32'h200004 + 32'h1000 * c); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [25:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(logic [25:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic drain(int c);
    logic [31:0] v;
    for (int i = 0; i <= NSRC; i++) begin
      rd(a_clm(c), v);
      if (v == 0) break;
      wr(a_clm(c), v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pr [1:NSRC];
    bit taken [1:NSRC];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    check("R1 irq", 32'(ctx_irq), 0);
    for (int k = 1; k <= NSRC; k++) begin rd(a_prio(k), v); check("R1 prio", v, 0); end
    rd(a_en(0), v);  check("R1 enable", v, 0);
    rd(a_thr(1), v); check("R1 threshold", v, 0);
    rd(a_clm(0), v); check("R1 claim", v, 0);

    wr(a_prio(3), 32'hFF); rd(a_prio(3), v); check("R2 width", v, 7);
    wr(a_prio(0), 5); rd(a_prio(0), v); check("R2 id0", v, 0);
    wr(a_prio(NSRC + 1), 5); rd(a_prio(NSRC + 1), v); check("R2 past last", v, 0);
    wr(a_prio(3), 0);

    wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), v);
    check("R3 enable bits", v, ((32'd1 << NSRC) - 1) << 1);
    rd(a_en(0), v); check("R3 other ctx", v, 0);
    wr(a_en(1), 0);

    wr(a_thr(1), 32'hFF); rd(a_thr(1), v); check("R4 width", v, 7);
    rd(a_thr(0), v); check("R4 other ctx", v, 0);
    wr(a_thr(1), 0);

    // R5 sweep: source 1 alone, each context, every priority/threshold pair
    src_i[1] = 1;
    @(negedge clk);
    for (int c = 0; c < NCTX; c++) begin
      wr(a_en(c), 32'h2);
      for (int t = 0; t < 8; t++) begin
        wr(a_thr(c), t);
        for (int p = 0; p < 8; p++) begin
          wr(a_prio(1), p);
          check($sformatf("R5 c%0d t%0d p%0d", c, t, p), 32'(ctx_irq), (p > t) ? (32'd1 << c) : 0);
        end
      end
      wr(a_thr(c), 0);
      wr(a_en(c), 0);
    end
    src_i[1] = 0;
    wr(a_en(0), 32'h7E);
    wr(a_prio(1), 1);
    drain(0);

    // R6 arbitration patterns with ties
    for (int pat = 0; pat < 4; pat++) begin
      int thr;
      thr = pat % 3;
      for (int k = 1; k <= NSRC; k++) begin
        pr[k] = (k * 5 + pat * 3) % 8;
        if (pat == 3) pr[k] = 4;
        taken[k] = 0;
        wr(a_prio(k), pr[k]);
      end
      wr(a_thr(0), thr);
      src_i = '1;
      @(negedge clk);
      for (int step = 0; step <= NSRC; step++) begin
        int bid, bp;
        bid = 0; bp = thr;
        for (int k = 1; k <= NSRC; k++)
          if (!taken[k] && pr[k] > bp) begin bp = pr[k]; bid = k; end
        check("R6 irq before claim", 32'(ctx_irq[0]), (bid != 0) ? 1 : 0);
        rd(a_clm(0), v);
        check($sformatf("R6 pattern %0d step %0d", pat, step), v, bid);
        if (bid == 0) break;
        taken[bid] = 1;
      end
      src_i = '0;
      for (int k = 1; k <= NSRC; k++) if (taken[k]) wr(a_clm(0), k);
      wr(a_thr(0), 0);
      for (int k = 1; k <= NSRC; k++) wr(a_prio(k), 1);
      drain(0);
      check("R8 quiet after drain", 32'(ctx_irq), 0);
    end
    for (int k = 1; k <= NSRC; k++) wr(a_prio(k), 0);
    wr(a_en(0), 0);

    // R7 / R9 / R8 ownership sequence on source 2
    wr(a_en(0), 32'h4); wr(a_en(1), 32'h4); wr(a_prio(2), 5);
    src_i[2] = 1;
    @(negedge clk);
    check("R5 both contexts", 32'(ctx_irq), 3);
    rd(a_clm(0), v); check("R6 claim src2", v, 2);
    check("R7 masked everywhere", 32'(ctx_irq), 0);
    repeat (4) @(negedge clk);
    check("R7 held input stays masked", 32'(ctx_irq), 0);
    wr(a_clm(1), 3);
    @(negedge clk);
    check("R9 stray complete irq", 32'(ctx_irq), 0);
    rd(a_clm(1), v); check("R9 stray complete claim", v, 0);
    wr(a_clm(1), 0);
    check("R9 zero complete", 32'(ctx_irq), 0);
    wr(a_clm(0), 2);
    @(negedge clk);
    check("R8 re-pend while high", 32'(ctx_irq), 3);
    rd(a_clm(1), v); check("R8 reclaim", v, 2);
    src_i[2] = 0;
    wr(a_clm(1), 2);
    @(negedge clk);
    check("R8 quiet when low", 32'(ctx_irq), 0);
    wr(a_en(1), 0);

    // R11 single-cycle pulse on source 4
    wr(a_en(0), 32'h10); wr(a_prio(4), 6);
    @(negedge clk); src_i[4] = 1;
    @(negedge clk); src_i[4] = 0;
    repeat (3) @(negedge clk);
    check("R11 pulse latched", 32'(ctx_irq), 1);
    rd(a_clm(0), v); check("R11 claim pulse", v, 4);
    wr(a_clm(0), 4);
    @(negedge clk);
    check("R11 released", 32'(ctx_irq), 0);

    // R10 read latency
    wr(a_thr(0), 3);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a_thr(0);
    #1 check("R10 not yet", bus_rdata, 0);
    @(negedge clk);
    bus_req = 0;
    check("R10 next cycle", bus_rdata, 3);
    @(negedge clk);
    check("R10 idle zero", bus_rdata, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule